// File: doc/BRIEF.md
# Forced-NOP Character Video Fetcher

This block sits beside a CPU and turns the CPU's own opcode fetches into a character display. The CPU jumps into a copy of the display file in the upper half of memory and fetches its bytes as opcodes. Each byte with bit 6 clear is taken as a character code. The block keeps the code, pulls the data bus to zero so the CPU executes a NOP, and then places the code and the current scan line into the address the CPU puts out during its refresh cycle. The byte that memory returns there is a row of the character's glyph. It is loaded into a shift register and sent out as eight serial pixels during the next four T-states.

Bytes with bit 6 set, such as the line terminator 0x76 or a return opcode, pass untouched and execute normally. In bitmap mode the CPU's refresh address already points at the bitmap, so the block adds no address bits but still loads and shifts the byte.

The block runs on a pixel clock at twice the CPU clock. An input tells it which half of the CPU clock the current pixel cycle falls in, so each T-state is two cycles: first the high half, then the low half.

Top module: `fnop_char_fetch`

## Requirements
- R1: A fetch is captured only when `m1_n` is low, `a15` is 1 and data bit 6 is 0, sampled at the end of the low half of T1. Any other fetch gets no bus forcing, no address and no shift-register load.
- R2: On capture, data bits 5..0 become the character code and data bit 7 becomes the invert flag for that character.
- R3: `bus_zero` is 1 exactly in the low half of T2 of a captured fetch and is 0 in every other cycle.
- R4: In character mode, during all four cycles of T3 and T4 of a captured fetch, `pat_oe` is 1 and `pat_addr` is {`page`[6:0], code[5:0], `line`[2:0]}. At all other times `pat_oe` is 0 and `pat_addr` is 0.
- R5: At the end of the high half of T4 of a captured fetch, the byte on `data_in` is loaded. Its bits appear on `pixel` MSB first, one per cycle, starting in the low half of T4, for eight cycles. Back-to-back captured fetches give a gapless stream.
- R6: When the character's invert flag is 1, every one of its eight pixels is complemented. A pixel value of 1 means black.
- R7: With `bitmap` at 1, `pat_oe` stays 0 and `pat_addr` stays 0, while capture, bus forcing and loading work as in R1, R3 and R5.
- R8: Once the eight pixels of a byte have been sent and no new load has occurred, `pixel` is 0 (white), whatever the invert flag.
- R9: While `rst_n` is low, `bus_zero`, `pat_oe`, `pat_addr` and `pixel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, twice the CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_hi | input | 1 | 1 in the high half of each T-state |
| m1_n | input | 1 | Opcode fetch strobe, low in T1 and T2 |
| rfsh_n | input | 1 | Refresh strobe, low in T3 and T4 |
| a15 | input | 1 | Top address bit during the fetch |
| bitmap | input | 1 | 1 selects bitmap mode (no address splice) |
| data_in | input | 8 | CPU data bus as seen by the block |
| page | input | 7 | Refresh-high register bits driven on A15..A9 |
| line | input | 3 | Scan line within the character row |
| bus_zero | output | 1 | 1 forces the data bus to all zeros |
| pat_oe | output | 1 | Enable for `pat_addr` onto the address bus |
| pat_addr | output | 16 | Glyph address, 0 when not enabled |
| pixel | output | 1 | Serial pixel, 1 = black |

## Verification
The assertions watch, on every cycle, that forcing and address drive never overlap, that the address is driven only inside a refresh phase and never in bitmap mode, that the spliced code stays steady across the refresh, and that forcing lasts a single cycle. Which fetches get captured, the exact cycle of each pixel, MSB-first order, inversion and the return to white can only be shown by the bench. Its reference model predicts every output on every cycle from the fetch sequence it drives, including terminator bytes, lower-half fetches, idle gaps and bitmap rows.

// File: rtl/fnop_char_fetch.sv
module fnop_char_fetch #(
  parameter int PIX_W  = 8,
  parameter int CHR_W  = 6,
  parameter int LINE_W = 3,
  parameter int PAGE_W = 7
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cpu_hi,
  input  logic                                m1_n,
  input  logic                                rfsh_n,
  input  logic                                a15,
  input  logic                                bitmap,
  input  logic [PIX_W-1:0]                    data_in,
  input  logic [PAGE_W-1:0]                   page,
  input  logic [LINE_W-1:0]                   line,
  output logic                                bus_zero,
  output logic                                pat_oe,
  output logic [PAGE_W+CHR_W+LINE_W-1:0]      pat_addr,
  output logic                                pixel
);
  localparam int AW   = PAGE_W + CHR_W + LINE_W;
  localparam int CNTW = $clog2(PIX_W + 1);
  localparam int SEL  = PIX_W - 2;
  localparam int INV  = PIX_W - 1;

  logic [1:0]       tq;
  logic             cap, chr_inv, px_inv;
  logic [CHR_W-1:0] chr;
  logic [PIX_W-1:0] sr;
  logic [CNTW-1:0]  cnt;

  logic active, grab, load, t_end;
  assign active = !m1_n || !rfsh_n;
  assign t_end  = active && !cpu_hi;
  assign grab   = !m1_n && rfsh_n && tq == 2'd0 && !cpu_hi && a15 && !data_in[SEL];
  assign load   = cap && !rfsh_n && tq == 2'd3 && cpu_hi;

  assign bus_zero = cap && !m1_n && tq == 2'd1 && !cpu_hi;
  assign pat_oe   = cap && !bitmap && !rfsh_n;
  assign pat_addr = pat_oe ? {page, chr, line} : AW'(0);
  assign pixel    = (cnt != '0) && (sr[PIX_W-1] ^ px_inv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tq      <= '0;
      cap     <= 1'b0;
      chr     <= '0;
      chr_inv <= 1'b0;
    end else begin
      if (!active)    tq <= '0;
      else if (t_end) tq <= tq + 2'd1;
      if (grab) begin
        cap     <= 1'b1;
        chr     <= data_in[CHR_W-1:0];
        chr_inv <= data_in[INV];
      end else if (!active || (t_end && tq == 2'd3)) begin
        cap <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr     <= '0;
      cnt    <= '0;
      px_inv <= 1'b0;
    end else if (load) begin
      sr     <= data_in;
      cnt    <= CNTW'(PIX_W);
      px_inv <= chr_inv;
    end else if (cnt != '0) begin
      sr  <= sr << 1;
      cnt <= cnt - 1'b1;
    end
  end

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    bus_zero |-> !pat_oe);
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_zero |=> !bus_zero);
  a_r4_addr_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    pat_oe |-> (!rfsh_n && m1_n));
  a_r4_code_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_oe && $past(pat_oe)) |-> $stable(pat_addr[LINE_W+CHR_W-1:LINE_W]));
  a_r7_bitmap_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bitmap |-> (!pat_oe && pat_addr == '0));
endmodule

// File: tb/tb_fnop_char_fetch.sv
module tb_fnop_char_fetch;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n = 1'b0, cpu_hi = 1'b1, m1_n = 1'b1, rfsh_n = 1'b1;
  logic        a15 = 1'b0, bmode = 1'b0;
  logic [7:0]  data = 8'h00;
  logic [6:0]  page = 7'h1E;
  logic [2:0]  line = 3'd0;
  logic        bus_zero, pat_oe, pixel;
  logic [15:0] pat_addr;

  fnop_char_fetch dut (
    .clk(clk), .rst_n(rst_n), .cpu_hi(cpu_hi), .m1_n(m1_n), .rfsh_n(rfsh_n),
    .a15(a15), .bitmap(bmode), .data_in(data), .page(page), .line(line),
    .bus_zero(bus_zero), .pat_oe(pat_oe), .pat_addr(pat_addr), .pixel(pixel));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  bit checking = 1'b0;
  bit          exp_pix [int];
  bit          exp_zero[int];
  logic [16:0] exp_pat [int];

  function automatic logic [7:0] mem(input logic [15:0] a);
    logic [7:0] v;
    v = a[7:0] * 8'd37;
    return v ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (checking) begin
    check("R5 R6 R8 pixel", {16'h0, pixel}, {16'h0, exp_pix.exists(cyc) ? exp_pix[cyc] : 1'b0});
    check("R1 R2 R3 bus_zero", {16'h0, bus_zero}, {16'h0, exp_zero.exists(cyc) ? exp_zero[cyc] : 1'b0});
    check("R1 R2 R4 R7 address", {pat_oe, pat_addr}, exp_pat.exists(cyc) ? exp_pat[cyc] : 17'h0);
  end

  task automatic fetch(input bit hi, input logic [7:0] op, input logic [7:0] rlow);
    int c0;
    bit elig;
    logic [15:0] ma;
    logic [7:0] pb;
    elig = hi && !op[6];
    ma = bmode ? {page, 1'b0, rlow} : {page, op[5:0], line};
    pb = mem(ma);
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1;
      if (k == 0) begin
        c0 = cyc;
        if (elig) begin
          exp_zero[c0+3] = 1'b1;
          if (!bmode) for (int j = 4; j < 8; j++) exp_pat[c0+j] = {1'b1, ma};
          for (int i = 0; i < 8; i++) exp_pix[c0+7+i] = pb[7-i] ^ op[7];
        end
      end
      cpu_hi = (k % 2 == 0);
      m1_n   = (k >= 4);
      rfsh_n = (k < 4);
      data   = (k < 4) ? op : pb;
      a15    = (k < 4) ? hi : 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      cpu_hi = (k % 2 == 0);
      m1_n = 1'b1; rfsh_n = 1'b1; a15 = 1'b0; data = 8'hFF;
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R9: outputs quiet in reset, even with an eligible fetch on the bus
    fetch(1'b1, 8'h26, 8'h00);
    @(negedge clk);
    check("R9 reset outputs", {bus_zero, pat_oe, pixel, pat_addr[13:0]}, 17'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    exp_pix.delete(); exp_zero.delete(); exp_pat.delete();
    idle(4);
    @(posedge clk); #1;
    checking = 1'b1;

    // R1 R2 R4 R5 R6: a row of plain and inverted characters ended by 0x76
    line = 3'd0;
    fetch(1, 8'h26, 0); fetch(1, 8'hA6, 0); fetch(1, 8'h3F, 0);
    fetch(1, 8'hBF, 0); fetch(1, 8'h00, 0); fetch(1, 8'h76, 0);
    idle(12);
    // R8: white after drain even following an inverted character
    line = 3'd5;
    fetch(1, 8'h8A, 0); idle(14);
    fetch(1, 8'h11, 0); fetch(1, 8'h76, 0); fetch(1, 8'h2C, 0);
    idle(10);
    // R1: lower half fetch and bit-6 opcodes are not captured
    fetch(0, 8'h12, 0); fetch(1, 8'h40, 0); fetch(1, 8'hC9, 0); fetch(0, 8'h80, 0);
    idle(6);
    // R4: every scan line of a row
    for (int l = 0; l < 8; l++) begin
      line = 3'(l);
      fetch(1, 8'h1D, 0); fetch(1, 8'h9D, 0); fetch(1, 8'h76, 0);
      idle(4);
    end
    // R7: bitmap mode, real NOPs with an advancing refresh low byte
    bmode = 1'b1;
    for (int r = 0; r < 6; r++) fetch(1, 8'h00, 8'(8'h40 + r));
    fetch(1, 8'h76, 8'h46);
    idle(12);
    bmode = 1'b0;
    line = 3'd7;
    fetch(1, 8'h3A, 0); fetch(1, 8'hBA, 0);
    idle(16);
    checking = 1'b0;
    summary();
    $finish;
  end
endmodule